// File: doc/BRIEF.md
# GPIO port with interrupt-on-change

This block is the per-pin core of a general-purpose I/O expander with 8 or 16 pins. It keeps the registers that set each pin's direction, input inversion, pull-up and output level, and it drives the pad output enables and values from them. A register access block on the same chip reaches it through a plain address, data and strobe port. Reads return data one clock after the strobe.

Inputs pass through a two-flop synchronizer. Each enabled pin is compared either with its value on the previous clock or with a programmed reference bit. The first mismatch on an enabled pin records which pins caused the event in a flag register. The same edge copies the port value into a capture register. Both registers then hold still until software reads the port or the capture register.

The interrupt output is split into one signal per group of eight pins. Each signal has a programmable active level and can be switched to open-drain drive. In the 16-pin variant, the two group signals can be combined so that both outputs assert together.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register (address 0x0) reads all ones, `pin_oe` is all zero, and `pu_en` is zero. Each interrupt output is driven with `int_oe` set and sits at its inactive level, which is high with the reset configuration.
- R2: A direction bit of 0 turns the pin into an output, so `pin_oe` equals the inverse of the direction register. `pin_out` equals the output latch register (address 0xA) one clock after that register is written.
- R3: A read of the port register (address 0x9) returns the synchronized pin levels XOR the polarity register (address 0x1). `pu_en` follows the pull-up register (address 0x6).
- R4: A pin raises an event only when its enable bit (address 0x2) is 1. When its control bit (address 0x4) is 0, the event is a change from the pin's previous synchronized value.
- R5: When a pin's control bit is 1, the pin raises an event whenever its synchronized value differs from its bit in the reference register (address 0x3). This repeats as long as the mismatch lasts.
- R6: On an event, the flag register (address 0x7) gets a 1 for each pin that caused it. The capture register (address 0x8) takes the port value at the same moment. Both stay frozen while any flag bit is set.
- R7: A read of the port or capture register returns the current value and clears every flag bit on the same clock edge. Reading the flag register does not clear it.
- R8: Writes to the flag and capture registers are ignored.
- R9: Configuration register (address 0x5) bit 1 selects the interrupt level: 1 means active-high and 0 means active-low. An output is active while any flag bit in its group of eight pins is set.
- R10: Configuration bit 2 selects open-drain drive. In that mode an active output has `int_oe`=1 and `int_out`=0, and an inactive output has `int_oe`=0.
- R11: With 16 pins, configuration bit 6 makes both interrupt outputs active when any flag bit is set. Without it, pins 0-7 drive output 0 and pins 8-15 drive output 1.
- R12: A change on an enabled pin sets its flag on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data, valid the clock after `rd_en` |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| pu_en | output | NPINS | Pull-up enables |
| int_out | output | NPINS/8 | Interrupt output level per pin group |
| int_oe | output | NPINS/8 | Interrupt output enable per pin group |

## Verification
The assertions check four things on every cycle. A direction or latch write must reach the pads on the next clock. The flag and capture registers must stay frozen while an event is pending and no clearing read occurs. A port or capture read must leave no flag set. A new flag may only appear on a pin whose enable bit was set.

Some behaviour can only be shown by the bench's scenarios. These cover the three-edge latency from pin to flag, and the difference between change detection and reference comparison, including the re-trigger after a clear while a mismatch remains. They also cover the interrupt level, open-drain drive and group mirroring at the output pins, and the read-back values of the port and capture registers under several polarity settings.

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pu_en,
  output logic [NPINS/8-1:0] int_out,
  output logic [NPINS/8-1:0] int_oe
);
  localparam int NB = NPINS / 8;
  localparam logic [3:0] A_DIR = 4'h0, A_POL = 4'h1, A_IEN = 4'h2, A_REF = 4'h3,
                         A_CTL = 4'h4, A_CFG = 4'h5, A_PUP = 4'h6, A_FLG = 4'h7,
                         A_CAP = 4'h8, A_PRT = 4'h9, A_LAT = 4'hA;

  logic [NPINS-1:0] dir_q, pol_q, ien_q, ref_q, ctl_q, pup_q, lat_q;
  logic [NPINS-1:0] flg_q, cap_q, sy1_q, sy2_q, prv_q;
  logic cfg_pol, cfg_odr, cfg_mir;
  logic [NPINS-1:0] port_v, miss, cfg_rd;
  logic clr_rd;

  assign port_v  = sy2_q ^ pol_q;
  assign miss    = ien_q & ((ctl_q & (sy2_q ^ ref_q)) | (~ctl_q & (sy2_q ^ prv_q)));
  assign clr_rd  = rd_en && (addr == A_PRT || addr == A_CAP);
  assign pin_oe  = ~dir_q;
  assign pin_out = lat_q;
  assign pu_en   = pup_q;
  assign cfg_rd  = {{(NPINS-7){1'b0}}, cfg_mir, 3'b000, cfg_odr, cfg_pol, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1; pol_q <= '0; ien_q <= '0; ref_q <= '0; ctl_q <= '0;
      pup_q <= '0; lat_q <= '0;
      cfg_pol <= 1'b0; cfg_odr <= 1'b0; cfg_mir <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_DIR: dir_q <= wdata;
        A_POL: pol_q <= wdata;
        A_IEN: ien_q <= wdata;
        A_REF: ref_q <= wdata;
        A_CTL: ctl_q <= wdata;
        A_CFG: begin cfg_pol <= wdata[1]; cfg_odr <= wdata[2]; cfg_mir <= wdata[6]; end
        A_PUP: pup_q <= wdata;
        A_LAT: lat_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0; sy2_q <= '0; prv_q <= '0; flg_q <= '0; cap_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      prv_q <= sy2_q;
      if (clr_rd)
        flg_q <= '0;
      else if (flg_q == '0 && miss != '0) begin
        flg_q <= miss;
        cap_q <= port_v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_DIR: rdata <= dir_q;
        A_POL: rdata <= pol_q;
        A_IEN: rdata <= ien_q;
        A_REF: rdata <= ref_q;
        A_CTL: rdata <= ctl_q;
        A_CFG: rdata <= cfg_rd;
        A_PUP: rdata <= pup_q;
        A_FLG: rdata <= flg_q;
        A_CAP: rdata <= cap_q;
        A_PRT: rdata <= port_v;
        A_LAT: rdata <= lat_q;
        default: rdata <= '0;
      endcase
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_irq
    logic act;
    if (NB > 1) begin : g_mir
      assign act = cfg_mir ? (flg_q != '0) : (flg_q[b*8 +: 8] != '0);
    end else begin : g_one
      assign act = (flg_q != '0);
    end
    assign int_oe[b]  = cfg_odr ? act : 1'b1;
    assign int_out[b] = cfg_odr ? 1'b0 : (cfg_pol ? act : ~act);
  end

  p_dir_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> pin_oe == ~$past(wdata));
  p_lat_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LAT) |=> pin_out == $past(wdata));
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q != '0 && !clr_rd) |=> ($stable(flg_q) && $stable(cap_q)));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> flg_q == '0);
  p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q == '0) |=> ((flg_q & ~$past(ien_q)) == '0));
endmodule

// File: tb/gpio_ioc_port_test.sv
`timescale 1ns/1ps
module gpio_ioc_port_test;
  localparam int N = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe, pu_en;
  logic [1:0] int_out, int_oe;
  int errors = 0, checks = 0;
  logic [N-1:0] rv;

  gpio_ioc_port #(.NPINS(N)) uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pu_en(pu_en), .int_out(int_out), .int_oe(int_oe));

  always #2.5 clk = ~clk;

  // {polarity, pins, expected port read} for R3
  localparam logic [47:0] VEC [4] = '{
    {16'h0000, 16'h00F0, 16'h00F0},
    {16'h00FF, 16'h00F0, 16'h000F},
    {16'hA5A5, 16'hFFFF, 16'h5A5A},
    {16'hFFFF, 16'h1234, 16'hEDCB}};

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pins(logic [N-1:0] v, int waitc);
    @(negedge clk); pin_in = v;
    repeat (waitc) @(negedge clk);
  endtask

  initial begin
    #1ms;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, rv); chk("R1 dir", rv, 16'hFFFF);
    chk("R1 pin_oe", pin_oe, 0); chk("R1 pu_en", pu_en, 0);
    chk("R1 int_out", {14'd0, int_out}, 16'h3); chk("R1 int_oe", {14'd0, int_oe}, 16'h3);
    // R3 vector table
    foreach (VEC[i]) begin
      wr(4'h1, VEC[i][47:32]);
      pins(VEC[i][31:16], 3);
      rd(4'h9, rv); chk("R3 port", rv, VEC[i][15:0]);
    end
    wr(4'h1, 0); pins(0, 3);
    wr(4'h6, 16'h1234); chk("R3 pu_en", pu_en, 16'h1234);
    // R2
    wr(4'h0, 16'hFF00); wr(4'hA, 16'h00A5);
    chk("R2 pin_oe", pin_oe, 16'h00FF); chk("R2 pin_out", pin_out, 16'h00A5);
    // R4 change mode, disabled pin ignored
    wr(4'h2, 16'h0001); wr(4'h4, 16'h0000);
    pins(16'h0020, 4);
    chk("R4 disabled pin no irq", {14'd0, int_out}, 16'h3);
    rd(4'h7, rv); chk("R4 flag empty", rv, 0);
    // R12 latency
    @(negedge clk); pin_in = 16'h0021;
    repeat (2) @(negedge clk);
    chk("R12 not before third edge", {14'd0, int_out}, 16'h3);
    @(negedge clk);
    chk("R12 third edge / R11 group A only", {14'd0, int_out}, 16'h2);
    rd(4'h7, rv); chk("R6 flag", rv, 16'h0001);
    pins(16'h0020, 3);
    rd(4'h7, rv); chk("R6 flag frozen", rv, 16'h0001);
    rd(4'h8, rv); chk("R6 capture frozen", rv, 16'h0021);
    chk("R7 capture read clears", {14'd0, int_out}, 16'h3);
    repeat (4) @(negedge clk);
    rd(4'h7, rv); chk("R7 no event after clear", rv, 0);
    // R5 reference compare
    wr(4'h2, 16'h0002); wr(4'h4, 16'h0002); wr(4'h3, 16'h0000);
    pins(16'h0022, 3);
    chk("R5 ref mismatch", {14'd0, int_out}, 16'h2);
    rd(4'h9, rv); chk("R7 port read value", rv, 16'h0022);
    chk("R7 port read clears", {14'd0, int_out}, 16'h3);
    @(negedge clk);
    chk("R5 retrigger", {14'd0, int_out}, 16'h2);
    pins(16'h0020, 3);
    rd(4'h9, rv);
    repeat (3) @(negedge clk);
    chk("R5 match no event", {14'd0, int_out}, 16'h3);
    // R8
    wr(4'h7, 16'hFFFF); wr(4'h8, 16'hFFFF);
    rd(4'h7, rv); chk("R8 flag write ignored", rv, 0);
    rd(4'h8, rv); chk("R8 capture write ignored", rv, 16'h0022);
    chk("R8 no irq", {14'd0, int_out}, 16'h3);
    // R9 active-high
    wr(4'h2, 16'h0001); wr(4'h4, 16'h0000); wr(4'h5, 16'h0002);
    chk("R9 inactive high-pol", {14'd0, int_out}, 16'h0);
    pins(16'h0021, 3);
    chk("R9 active high", {14'd0, int_out}, 16'h1);
    rd(4'h9, rv);
    chk("R9 cleared", {14'd0, int_out}, 16'h0);
    // R11 group B without mirror
    wr(4'h2, 16'h1000);
    pins(16'h1021, 3);
    chk("R11 group B only", {14'd0, int_out}, 16'h2);
    // R10 open drain
    wr(4'h5, 16'h0004);
    chk("R10 od oe", {14'd0, int_oe}, 16'h2);
    chk("R10 od out", {14'd0, int_out}, 16'h0);
    rd(4'h9, rv);
    chk("R10 od released", {14'd0, int_oe}, 16'h0);
    // R11 mirror
    wr(4'h5, 16'h0042);
    rd(4'h5, rv); chk("R11 cfg read", rv, 16'h0042);
    pins(16'h0021, 3);
    chk("R11 mirror both", {14'd0, int_out}, 16'h3);
    chk("R11 mirror oe", {14'd0, int_oe}, 16'h3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule